// File: doc/BRIEF.md
# Dual-Port Block Memory with Hold-on-Write Output

This block is a synchronous memory with two fully independent ports, A and B. Each port has its own clock, enable, write enable, synchronous set/reset, address, write data and registered read data. It is used as a shared buffer between two agents. The two agents may run on unrelated clocks, and each can read and write any word.

A port's read data output is a register. A read appears one active edge after it is requested. During a write cycle the register keeps whatever it last captured, so a write never disturbs the read data. A set/reset loads a per-port constant into that register. This constant is separate from the value the register holds at power-up. The power-up memory image is a linear ramp, `INIT_BASE + i*INIT_STEP` for word `i`. Every control input of each port, including its clock, has a polarity parameter.

Storage is split into one bank per port. A bit per word in each bank records which bank holds the newest copy of that word. This way each storage element is written from a single clock domain.

Top module: `bram_nc_dp`

## Requirements
- R1: With the port's effective enable high and effective write enable and set/reset low, the word at the address appears on that port's read data after the active edge. This is one cycle of latency.
- R2: While a port's effective enable is low, its write enable, set/reset and address have no effect. Its read data holds, and the memory is not written.
- R3: With effective enable and write enable high, the port's write data is stored at the port's address on the active edge. A later read from either port returns it.
- R4: With effective enable and set/reset high, the port's read data becomes that port's set value after the edge: `SRVAL_A` for port A, `SRVAL_B` for port B.
- R5: During a write cycle without set/reset, the port's read data keeps the value it held before the write.
- R6: At power-up, read data A equals `INIT_A` and read data B equals `INIT_B`. Memory word `i` holds `INIT_BASE + i*INIT_STEP`, truncated to the data width.
- R7: A polarity parameter set to 1 inverts its input. For port B these are `INV_CLK_B`, `INV_EN_B`, `INV_WE_B` and `INV_SSR_B`. With inversion, the port is active on the falling edge of its pin, and an enable, write enable or set/reset is asserted by a low level.
- R8: When set/reset and write enable are both asserted with enable, the write still stores the data and the read data takes the set value.
- R9: With one shared effective clock, if both ports write the same address in the same cycle, port A's data is kept. A port reading an address that the other port writes in that cycle gets the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock pin |
| en_a | input | 1 | Port A enable pin |
| we_a | input | 1 | Port A write enable pin |
| ssr_a | input | 1 | Port A synchronous set/reset pin |
| addr_a | input | AW | Port A word address |
| din_a | input | DW | Port A write data |
| dout_a | output | DW | Port A registered read data |
| clk_b | input | 1 | Port B clock pin |
| en_b | input | 1 | Port B enable pin |
| we_b | input | 1 | Port B write enable pin |
| ssr_b | input | 1 | Port B synchronous set/reset pin |
| addr_b | input | AW | Port B word address |
| din_b | input | DW | Port B write data |
| dout_b | output | DW | Port B registered read data |

## Verification
The bench builds an 8-bit by 16-word memory, so the whole image ramp (base 0x30, step 3) is read back word by word. The power-up and set values are distinct nonzero patterns per port, so a swap or a zero load shows at once. Port A runs with normal polarity. Port B has every control inverted, including the clock, and its clock pin is driven with the complement of port A's clock. The two effective clocks then coincide, which brings same-cycle collisions and cross-port reads of a word being written within reach on one shared edge.

// File: rtl/bram_nc_pkg.sv
package bram_nc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_WRITE,
        OP_SET
    } port_op_e;

    // set/reset outranks write for the output register; write outranks read
    function automatic port_op_e decode_op(input logic en, input logic we, input logic ssr);
        if (!en)      return OP_IDLE;
        else if (ssr) return OP_SET;
        else if (we)  return OP_WRITE;
        else          return OP_READ;
    endfunction

endpackage

// File: rtl/bram_nc_bank.sv
module bram_nc_bank #(
    parameter int          DW        = 16,
    parameter int          AW        = 9,
    parameter bit          TAG_INV   = 1'b0,
    parameter logic [DW-1:0] INIT_BASE = '0,
    parameter logic [DW-1:0] INIT_STEP = '0
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          other_tag,
    input  logic [AW-1:0] rd0_addr,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd0_data,
    output logic          rd0_tag,
    output logic [DW-1:0] rd1_data,
    output logic          rd1_tag
);
    localparam int DEPTH = 1 << AW;

    typedef logic [DW-1:0] image_t [DEPTH];

    function automatic image_t build_image();
        image_t img;
        for (int i = 0; i < DEPTH; i++) begin
            img[i] = INIT_BASE + DW'(i) * INIT_STEP;
        end
        return img;
    endfunction

    image_t            mem_q = build_image();
    logic [DEPTH-1:0]  tag_q = '0;
    logic              armed_q = 1'b0;

    // write side: data plus the "newest copy" marker for the word
    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
            tag_q[wr_addr] <= other_tag ^ TAG_INV;
        end
    end

    assign rd0_data = mem_q[rd0_addr];
    assign rd0_tag  = tag_q[rd0_addr];
    assign rd1_data = mem_q[rd1_addr];
    assign rd1_tag  = tag_q[rd1_addr];

    assert_write_stored_R3: assert property (@(posedge clk) disable iff (!armed_q)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/bram_nc_outreg.sv
module bram_nc_outreg #(
    parameter int            DW       = 16,
    parameter logic [DW-1:0] INIT_VAL = '0,
    parameter logic [DW-1:0] SR_VAL   = '0
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic          ssr,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dout
);
    import bram_nc_pkg::*;

    typedef struct packed {
        logic [DW-1:0] dout;
    } out_state_t;

    out_state_t st_d;
    out_state_t st_q    = '{dout: INIT_VAL};
    logic       armed_q = 1'b0;
    port_op_e   op;

    assign op = decode_op(en, we, ssr);

    always_comb begin
        st_d = st_q;
        case (op)
            OP_SET:  st_d.dout = SR_VAL;
            OP_READ: st_d.dout = rd_data;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
        st_q    <= st_d;
    end

    assign dout = st_q.dout;

    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!armed_q)
        (en && !we && !ssr) |=> dout == $past(rd_data));

    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!armed_q)
        !en |=> $stable(dout));

    assert_set_value_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (en && ssr) |=> dout == SR_VAL);

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (!armed_q)
        (en && we && !ssr) |=> $stable(dout));

endmodule

// File: rtl/bram_nc_dp.sv
module bram_nc_dp #(
    parameter int            DW        = 16,
    parameter int            AW        = 9,
    parameter logic [DW-1:0] INIT_BASE = '0,
    parameter logic [DW-1:0] INIT_STEP = '0,
    parameter logic [DW-1:0] INIT_A    = '0,
    parameter logic [DW-1:0] INIT_B    = '0,
    parameter logic [DW-1:0] SRVAL_A   = '0,
    parameter logic [DW-1:0] SRVAL_B   = '0,
    parameter bit            INV_CLK_A = 1'b0,
    parameter bit            INV_EN_A  = 1'b0,
    parameter bit            INV_WE_A  = 1'b0,
    parameter bit            INV_SSR_A = 1'b0,
    parameter bit            INV_CLK_B = 1'b0,
    parameter bit            INV_EN_B  = 1'b0,
    parameter bit            INV_WE_B  = 1'b0,
    parameter bit            INV_SSR_B = 1'b0
) (
    input  logic          clk_a,
    input  logic          en_a,
    input  logic          we_a,
    input  logic          ssr_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] din_a,
    output logic [DW-1:0] dout_a,
    input  logic          clk_b,
    input  logic          en_b,
    input  logic          we_b,
    input  logic          ssr_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] din_b,
    output logic [DW-1:0] dout_b
);
    // effective (polarity-corrected) controls
    logic ck_a, en_a_e, we_a_e, ssr_a_e;
    logic ck_b, en_b_e, we_b_e, ssr_b_e;

    assign ck_a    = clk_a ^ INV_CLK_A;
    assign en_a_e  = en_a  ^ INV_EN_A;
    assign we_a_e  = we_a  ^ INV_WE_A;
    assign ssr_a_e = ssr_a ^ INV_SSR_A;
    assign ck_b    = clk_b ^ INV_CLK_B;
    assign en_b_e  = en_b  ^ INV_EN_B;
    assign we_b_e  = we_b  ^ INV_WE_B;
    assign ssr_b_e = ssr_b ^ INV_SSR_B;

    // port A wins a same-address write in a shared cycle
    logic wr_a, wr_b;
    assign wr_a = en_a_e && we_a_e;
    assign wr_b = en_b_e && we_b_e && !(wr_a && (addr_a == addr_b));

    logic [DW-1:0] a_d0, a_d1, b_d0, b_d1;
    logic          a_t0, a_t1, b_t0, b_t1;

    // bank A marks a word newest by making its tag equal bank B's
    bram_nc_bank #(
        .DW(DW), .AW(AW), .TAG_INV(1'b0),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) i_bank_a (
        .clk(ck_a), .wr_en(wr_a), .wr_addr(addr_a), .wr_data(din_a),
        .other_tag(b_t0),
        .rd0_addr(addr_a), .rd1_addr(addr_b),
        .rd0_data(a_d0), .rd0_tag(a_t0),
        .rd1_data(a_d1), .rd1_tag(a_t1)
    );

    // bank B marks a word newest by making its tag differ from bank A's
    bram_nc_bank #(
        .DW(DW), .AW(AW), .TAG_INV(1'b1),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) i_bank_b (
        .clk(ck_b), .wr_en(wr_b), .wr_addr(addr_b), .wr_data(din_b),
        .other_tag(a_t1),
        .rd0_addr(addr_a), .rd1_addr(addr_b),
        .rd0_data(b_d0), .rd0_tag(b_t0),
        .rd1_data(b_d1), .rd1_tag(b_t1)
    );

    logic [DW-1:0] rd_a, rd_b;
    assign rd_a = (a_t0 ^ b_t0) ? b_d0 : a_d0;
    assign rd_b = (a_t1 ^ b_t1) ? b_d1 : a_d1;

    bram_nc_outreg #(.DW(DW), .INIT_VAL(INIT_A), .SR_VAL(SRVAL_A)) i_out_a (
        .clk(ck_a), .en(en_a_e), .we(we_a_e), .ssr(ssr_a_e),
        .rd_data(rd_a), .dout(dout_a)
    );

    bram_nc_outreg #(.DW(DW), .INIT_VAL(INIT_B), .SR_VAL(SRVAL_B)) i_out_b (
        .clk(ck_b), .en(en_b_e), .we(we_b_e), .ssr(ssr_b_e),
        .rd_data(rd_b), .dout(dout_b)
    );

endmodule

// File: tb/test_bram_nc_dp.sv
module test_bram_nc_dp;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] BASE = 8'h30, STEP = 8'h03;
    localparam logic [DW-1:0] IA = 8'hA5, IB = 8'h5A, SA = 8'hC3, SB = 8'h3C;

    logic clk = 1'b0;
    logic clk_b;
    logic en_a = 0, we_a = 0, ssr_a = 0;
    logic en_b = 1, we_b = 1, ssr_b = 1;   // port B pins are active low
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] din_a = '0, din_b = '0;
    logic [DW-1:0] dout_a, dout_b;
    logic [DW-1:0] em [DEPTH];
    int n_run = 0, n_fail = 0;

    assign clk_b = ~clk;
    always #(CLK_PERIOD/2) clk = ~clk;

    bram_nc_dp #(
        .DW(DW), .AW(AW), .INIT_BASE(BASE), .INIT_STEP(STEP),
        .INIT_A(IA), .INIT_B(IB), .SRVAL_A(SA), .SRVAL_B(SB),
        .INV_CLK_B(1'b1), .INV_EN_B(1'b1), .INV_WE_B(1'b1), .INV_SSR_B(1'b1)
    ) i_bram_nc_dp (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle on both ports, logical levels; returns just after the shared edge
    task automatic step(input logic ea, wa, sa, input logic [AW-1:0] aa, input logic [DW-1:0] da,
                        input logic eb, wb, sb, input logic [AW-1:0] ab, input logic [DW-1:0] db);
        @(negedge clk);
        en_a = ea; we_a = wa; ssr_a = sa; addr_a = aa; din_a = da;
        en_b = ~eb; we_b = ~wb; ssr_b = ~sb; addr_b = ab; din_b = db;
        @(posedge clk);
        #1;
        if (ea && wa) em[aa] = da;
        if (eb && wb && !(ea && wa && aa == ab)) em[ab] = db;
    endtask

    task automatic idle();
        step(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
    endtask

    task automatic t_powerup();
        #1;
        check("R6 power-up A", dout_a, IA);
        check("R6 power-up B", dout_b, IB);
        idle(); idle();
        check("R2 idle A hold", dout_a, IA);
        check("R7 idle B hold (inverted)", dout_b, IB);
    endtask

    task automatic t_image();
        for (int i = 0; i < DEPTH; i++) begin
            step(1, 0, 0, AW'(i), '0, 1, 0, 0, AW'(DEPTH-1-i), '0);
            check("R6 image A", dout_a, BASE + DW'(i) * STEP);
            check("R1 R7 read B", dout_b, BASE + DW'(DEPTH-1-i) * STEP);
        end
    endtask

    task automatic t_write_hold();
        step(1, 0, 0, 4'd2, '0, 0, 0, 0, '0, '0);
        check("R1 read A", dout_a, em[2]);
        step(1, 1, 0, 4'd5, 8'h77, 0, 0, 0, '0, '0);
        check("R5 no change on write A", dout_a, em[2]);
        step(1, 0, 0, 4'd5, '0, 1, 0, 0, 4'd5, '0);
        check("R3 written A", dout_a, 8'h77);
        check("R3 cross read B", dout_b, 8'h77);
        step(0, 0, 0, '0, '0, 1, 1, 0, 4'd12, 8'h5C);
        check("R5 R7 no change on write B", dout_b, 8'h77);
        step(1, 0, 0, 4'd12, '0, 0, 0, 0, '0, '0);
        check("R3 B write read by A", dout_a, 8'h5C);
    endtask

    task automatic t_enable_low();
        step(1, 0, 0, 4'd3, '0, 1, 0, 0, 4'd4, '0);
        step(0, 1, 1, 4'd6, 8'hEE, 0, 1, 1, 4'd6, 8'hDD);
        check("R2 disabled A hold", dout_a, em[3]);
        check("R2 disabled B hold", dout_b, em[4]);
        step(1, 0, 0, 4'd6, '0, 0, 0, 0, '0, '0);
        check("R2 no write when disabled", dout_a, BASE + 8'd6 * STEP);
    endtask

    task automatic t_set();
        step(1, 0, 1, 4'd1, '0, 1, 0, 1, 4'd1, '0);
        check("R4 set A", dout_a, SA);
        check("R4 R7 set B", dout_b, SB);
        step(1, 1, 1, 4'd7, 8'h99, 0, 0, 0, '0, '0);
        check("R8 set with write A", dout_a, SA);
        step(1, 0, 0, 4'd7, '0, 0, 0, 0, '0, '0);
        check("R8 write kept", dout_a, 8'h99);
    endtask

    task automatic t_collide();
        step(1, 1, 0, 4'd9, 8'h11, 1, 1, 0, 4'd9, 8'h22);
        step(1, 0, 0, 4'd9, '0, 1, 0, 0, 4'd9, '0);
        check("R9 A wins A", dout_a, 8'h11);
        check("R9 A wins B", dout_b, 8'h11);
        step(1, 1, 0, 4'd10, 8'h44, 1, 0, 0, 4'd10, '0);
        check("R9 old data B", dout_b, BASE + 8'd10 * STEP);
        step(0, 0, 0, '0, '0, 1, 0, 0, 4'd10, '0);
        check("R9 new data B", dout_b, 8'h44);
        step(1, 0, 0, 4'd11, '0, 1, 1, 0, 4'd11, 8'h66);
        check("R9 old data A", dout_a, BASE + 8'd11 * STEP);
        step(1, 0, 0, 4'd11, '0, 0, 0, 0, '0, '0);
        check("R9 new data A", dout_a, 8'h66);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) em[i] = BASE + DW'(i) * STEP;
        t_powerup();
        t_image();
        t_write_hold();
        t_enable_low();
        t_set();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule